// File: doc/BRIEF.md
# DRAM Power-Down Controller

This block sits on the controller side of a DRAM channel and decides when the memory enters a power-down state, which kind of power-down it uses, and how it leaves. It watches the commands the scheduler issues and keeps an open-row flag for every bank. When the scheduler asks to go idle, it picks one of two states. If every bank is closed, it uses precharge power-down, the deepest state short of self-refresh, and freezes the DLL. If any row is open, it uses active power-down, with a fast or slow exit taken from a configuration bit.

It lowers CKE, keeps CKE low for a programmable minimum number of cycles, and reports the current power-down kind on a one-hot status bus. On a wake request it raises CKE and holds off new commands until an exit timer has run out. The timer has a short setting for a fast active exit and a longer DLL-relock setting for a slow active exit or a precharge exit. A counter of cycles since the last refresh forces an exit before the refresh deadline, and it refuses new entries once that deadline is close. An active power-down is never left while a clock-frequency change is requested. A precharge power-down may be left at any time.

Top module: `pdn_ctrl`

## Requirements
- R1: While reset is applied and right after it, `cke`=1, `ready`=1, `dll_freeze`=0 and `pd_type`=0. All bank flags start closed, and the refresh age starts at 0.
- R2: Bank flags are updated only by a command accepted while `ready`=1. The `cmd_op` encodings are 0 NOP, 1 ACTIVATE, 2 PRECHARGE, 3 PRECHARGE-ALL, 4 READ with auto-precharge, 5 WRITE with auto-precharge, 6 READ and 7 WRITE. ACTIVATE opens the addressed bank. Codes 2, 4 and 5 close the addressed bank, and code 3 closes every bank. Codes 0, 6 and 7 change no flag.
- R3: With `cfg_x16`=1 only 8 banks exist. Bit 3 of `cmd_bank` is ignored, so bank 9 and bank 1 name the same bank, and flags of banks 8 to 15 do not count as open.
- R4: From a ready state, `idle_req`=1 with `cmd_valid`=0 and no refresh urgency starts power-down entry. If no bank is open, the kind is precharge: `pd_type`=3'b001 and `dll_freeze`=1 for the whole time `cke` is low. `idle_req` in a cycle with `cmd_valid`=1 starts no entry.
- R5: If any bank is open at entry, the kind is active and `dll_freeze` stays 0. `pd_type` is 3'b010 when `cfg_slow_exit`=0 (fast exit) and 3'b100 when `cfg_slow_exit`=1 (slow exit). `pd_type` is 0 whenever `cke`=1.
- R6: After entry, `cke` stays low for at least max(`cfg_tcke`,1) cycles. A wake request during that time is not acted on until that time has passed.
- R7: On exit, `cke` rises and `ready` stays 0 for exactly max(`cfg_txp`,1) cycles after a fast active power-down. After a slow active or a precharge power-down it stays 0 for exactly max(`cfg_txpdll`,1) cycles. Then `ready` returns to 1.
- R8: `ready` is 0 whenever `cke` is 0. Commands presented while `ready`=0 are ignored and leave the bank flags unchanged.
- R9: An active power-down is not left while `freq_chg_req`=1, even with a wake request or refresh urgency pending. A precharge power-down exits on a wake request whatever `freq_chg_req` is.
- R10: Refresh urgency holds once REF_LIMIT−REF_GUARD cycles have passed since the last `ref_done` (or since reset). Urgency forces an exit from power-down with no wake request (subject to R9) and blocks any new entry. A `ref_done` pulse clears the urgency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_x16 | input | 1 | 1: 8-bank organisation, 0: 16-bank organisation |
| cfg_slow_exit | input | 1 | Exit type for active power-down: 0 fast, 1 slow |
| cfg_tcke | input | TIME_W | Minimum CKE-low cycles after entry |
| cfg_txp | input | TIME_W | Exit wait after fast active power-down |
| cfg_txpdll | input | TIME_W | Exit wait after slow active or precharge power-down |
| cmd_valid | input | 1 | Scheduler issues a command this cycle |
| cmd_op | input | 3 | Command code (see R2) |
| cmd_bank | input | BANK_W | Bank address {group, bank} |
| idle_req | input | 1 | Request to enter power-down |
| wake_req | input | 1 | Request to leave power-down |
| freq_chg_req | input | 1 | Clock-frequency change pending |
| ref_done | input | 1 | A refresh was just issued |
| cke | output | 1 | Clock-enable to the DRAM |
| dll_freeze | output | 1 | DLL frozen (precharge power-down only) |
| ready | output | 1 | Commands may be issued |
| pd_type | output | 3 | One-hot: bit0 precharge, bit1 active fast, bit2 active slow |

## Verification
The mode choice is driven with bank states that separate each command's effect: all closed, one row open, a row opened and then closed by each of the closing commands, a plain read or write that must leave the row open, and several banks opened with only some of them closed. Each of these must land in the matching precharge or active kind, so a command that closes or opens the wrong flag shows up as the wrong kind. Fast and slow settings tell the two active exits apart by their exit wait. The 8-bank runs aim a bank-9 command at bank 1, which exposes a tracker that keeps the upper bank. A command during power-down, a frequency-change request in each kind, and a run with no wake request that the refresh guard must end separate the hold-off rules from plain wake handling.

// File: rtl/pdn_pkg.sv
package pdn_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_PD_ENTRY = 3'd1,
    ST_PRE_PD   = 3'd2,
    ST_ACT_PD   = 3'd3,
    ST_PD_EXIT  = 3'd4,
    ST_READY    = 3'd5
  } pd_state_e;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_ACT  = 3'd1,
    OP_PRE  = 3'd2,
    OP_PREA = 3'd3,
    OP_RDA  = 3'd4,
    OP_WRA  = 3'd5,
    OP_RD   = 3'd6,
    OP_WR   = 3'd7
  } cmd_op_e;

  // index of the set bit in the one-hot status bus
  typedef enum logic [1:0] {
    KIND_PRE  = 2'd0,
    KIND_FAST = 2'd1,
    KIND_SLOW = 2'd2
  } pd_kind_e;

  localparam int TYPE_W = 3;

endpackage

// File: rtl/pdn_bank_track.sv
module pdn_bank_track
  import pdn_pkg::*;
#(
  parameter  int NUM_BANKS = 16,
  localparam int BANK_W    = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic              cmd_valid,
  input  cmd_op_e           cmd_op,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic              cfg_x16,
  output logic              any_open
);

  localparam int HALF = NUM_BANKS / 2;

  logic [BANK_W-1:0]    eff_bank;
  logic [NUM_BANKS-1:0] open_q;
  logic [NUM_BANKS-1:0] live_mask;
  logic                 take_cmd;

  // narrow organisation: top bank-address bit does not exist
  always_comb begin
    eff_bank = cfg_x16 ? {1'b0, cmd_bank[BANK_W-2:0]} : cmd_bank;
    take_cmd = upd_en && cmd_valid;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    logic nxt;

    assign sel = (eff_bank == BANK_W'(b));

    always_comb begin
      nxt = open_q[b];
      case (cmd_op)
        OP_ACT:                 if (sel) nxt = 1'b1;
        OP_PRE, OP_RDA, OP_WRA: if (sel) nxt = 1'b0;
        OP_PREA:                nxt = 1'b0;
        default:                nxt = open_q[b];
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        open_q[b] <= 1'b0;
      else if (take_cmd) open_q[b] <= nxt;
    end

    if (b < HALF) begin : g_low
      assign live_mask[b] = 1'b1;
    end else begin : g_high
      assign live_mask[b] = ~cfg_x16;
    end
  end

  assign any_open = |(open_q & live_mask);

  // R8: flags frozen while commands are not accepted
  p_flags_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(open_q));

  // R2: an accepted activate leaves some live bank open
  p_act_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && cmd_valid && cmd_op == OP_ACT) |=> any_open);

  // R2: precharge-all leaves nothing open
  p_prea_closes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && cmd_valid && cmd_op == OP_PREA) |=> !any_open);

endmodule

// File: rtl/pdn_ref_guard.sv
module pdn_ref_guard #(
  parameter  int REF_LIMIT = 7800,
  parameter  int REF_GUARD = 200,
  localparam int CW        = $clog2(REF_LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_done,
  output logic urgent
);

  localparam int            TRIP    = (REF_GUARD < REF_LIMIT) ? (REF_LIMIT - REF_GUARD) : 1;
  localparam logic [CW-1:0] TRIP_V  = CW'(TRIP);
  localparam logic [CW-1:0] LIMIT_V = CW'(REF_LIMIT);

  logic [CW-1:0] age_q;
  logic [CW-1:0] age_d;
  logic          age_en;

  // saturating age since the last refresh
  always_comb begin
    age_en = ref_done || (age_q != LIMIT_V);
    age_d  = ref_done ? '0 : (age_q + 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      age_q <= '0;
    else if (age_en) age_q <= age_d;
  end

  assign urgent = (age_q >= TRIP_V);

  // R10: a refresh clears the urgency on the next cycle
  p_ref_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ref_done |=> !urgent);

endmodule

// File: rtl/pdn_fsm.sv
module pdn_fsm
  import pdn_pkg::*;
#(
  parameter int TIME_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idle_req,
  input  logic              wake_req,
  input  logic              cmd_valid,
  input  logic              freq_chg_req,
  input  logic              any_open,
  input  logic              ref_urgent,
  input  logic              cfg_slow_exit,
  input  logic [TIME_W-1:0] cfg_tcke,
  input  logic [TIME_W-1:0] cfg_txp,
  input  logic [TIME_W-1:0] cfg_txpdll,
  output logic              cke,
  output logic              dll_freeze,
  output logic              ready,
  output logic [TYPE_W-1:0] pd_type
);

  pd_state_e         state_q, state_d;
  pd_kind_e          kind_q, kind_d;
  logic [TIME_W-1:0] cnt_q, cnt_d;
  logic              leave;
  logic              in_pd;

  // counts of zero behave as one cycle
  function automatic logic [TIME_W-1:0] preload(input logic [TIME_W-1:0] v);
    return (v == '0) ? '0 : (v - 1'b1);
  endfunction

  always_comb begin
    state_d = state_q;
    kind_d  = kind_q;
    cnt_d   = cnt_q;
    leave   = wake_req || ref_urgent;
    case (state_q)
      ST_IDLE, ST_READY: begin
        if (idle_req && !cmd_valid && !ref_urgent) begin
          state_d = ST_PD_ENTRY;
          cnt_d   = preload(cfg_tcke);
          if (!any_open)          kind_d = KIND_PRE;
          else if (cfg_slow_exit) kind_d = KIND_SLOW;
          else                    kind_d = KIND_FAST;
        end
      end
      ST_PD_ENTRY: begin
        if (cnt_q == '0) state_d = (kind_q == KIND_PRE) ? ST_PRE_PD : ST_ACT_PD;
        else             cnt_d   = cnt_q - 1'b1;
      end
      ST_PRE_PD: begin
        if (leave) begin
          state_d = ST_PD_EXIT;
          cnt_d   = preload(cfg_txpdll);
        end
      end
      ST_ACT_PD: begin
        if (leave && !freq_chg_req) begin
          state_d = ST_PD_EXIT;
          cnt_d   = (kind_q == KIND_FAST) ? preload(cfg_txp) : preload(cfg_txpdll);
        end
      end
      ST_PD_EXIT: begin
        if (cnt_q == '0) state_d = ST_READY;
        else             cnt_d   = cnt_q - 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= KIND_PRE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      cnt_q   <= cnt_d;
    end
  end

  always_comb begin
    in_pd      = (state_q == ST_PD_ENTRY) || (state_q == ST_PRE_PD) || (state_q == ST_ACT_PD);
    cke        = !in_pd;
    ready      = (state_q == ST_IDLE) || (state_q == ST_READY);
    dll_freeze = in_pd && (kind_q == KIND_PRE);
    pd_type    = in_pd ? TYPE_W'(3'b001 << kind_q) : '0;
  end

  // ---------------------------------------------------------------
  // checks
  // ---------------------------------------------------------------
  logic [TIME_W:0] low_run;
  logic [TIME_W:0] min_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      low_run <= '0;
    else if (cke)                    low_run <= '0;
    else if (low_run != '1)          low_run <= low_run + 1'b1;
  end

  assign min_low = {1'b0, ((cfg_tcke == '0) ? TIME_W'(1) : cfg_tcke)};

  // R6: CKE stayed low long enough before rising
  p_min_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> (low_run >= min_low));

  // R9: active power-down held while a frequency change is pending
  p_freq_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACT_PD && freq_chg_req) |=> !cke);

  // R10: no entry when the refresh deadline is near
  p_no_entry_urgent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && ref_urgent) |=> cke);

  // R4: DLL frozen only in the precharge kind
  p_dll_pre_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dll_freeze |-> (pd_type == 3'b001));

  // R5: at most one kind reported
  p_type_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pd_type));

  // R7: wake in precharge power-down starts the exit wait
  p_wake_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PRE_PD && wake_req) |=> (cke && !ready));

endmodule

// File: rtl/pdn_ctrl.sv
module pdn_ctrl
  import pdn_pkg::*;
#(
  parameter  int NUM_BANKS = 16,
  parameter  int TIME_W    = 8,
  parameter  int REF_LIMIT = 7800,
  parameter  int REF_GUARD = 200,
  localparam int BANK_W    = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_x16,
  input  logic              cfg_slow_exit,
  input  logic [TIME_W-1:0] cfg_tcke,
  input  logic [TIME_W-1:0] cfg_txp,
  input  logic [TIME_W-1:0] cfg_txpdll,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic              idle_req,
  input  logic              wake_req,
  input  logic              freq_chg_req,
  input  logic              ref_done,
  output logic              cke,
  output logic              dll_freeze,
  output logic              ready,
  output logic [2:0]        pd_type
);

  logic [1:0] rst_pipe;
  logic       rst_n_int;
  logic       any_open;
  logic       ref_urgent;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_int = rst_pipe[1];

  pdn_bank_track #(
    .NUM_BANKS (NUM_BANKS)
  ) u_banks (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .upd_en    (ready),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op_e'(cmd_op)),
    .cmd_bank  (cmd_bank),
    .cfg_x16   (cfg_x16),
    .any_open  (any_open)
  );

  pdn_ref_guard #(
    .REF_LIMIT (REF_LIMIT),
    .REF_GUARD (REF_GUARD)
  ) u_refg (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .ref_done (ref_done),
    .urgent   (ref_urgent)
  );

  pdn_fsm #(
    .TIME_W (TIME_W)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n_int),
    .idle_req      (idle_req),
    .wake_req      (wake_req),
    .cmd_valid     (cmd_valid),
    .freq_chg_req  (freq_chg_req),
    .any_open      (any_open),
    .ref_urgent    (ref_urgent),
    .cfg_slow_exit (cfg_slow_exit),
    .cfg_tcke      (cfg_tcke),
    .cfg_txp       (cfg_txp),
    .cfg_txpdll    (cfg_txpdll),
    .cke           (cke),
    .dll_freeze    (dll_freeze),
    .ready         (ready),
    .pd_type       (pd_type)
  );

  // R8: no command acceptance while the clock-enable is low
  p_hold_when_low_r8: assert property (@(posedge clk) disable iff (!rst_n_int)
    !cke |-> !ready);

endmodule

// File: tb/tb_pdn_ctrl.sv
module tb_pdn_ctrl;

  localparam int TIME_W = 8;
  localparam int TCKE   = 3;
  localparam int TXP    = 2;
  localparam int TXPDLL = 6;
  localparam int RLIM   = 300;
  localparam int RGRD   = 40;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cfg_x16, cfg_slow_exit;
  logic [TIME_W-1:0] cfg_tcke, cfg_txp, cfg_txpdll;
  logic              cmd_valid;
  logic [2:0]        cmd_op;
  logic [3:0]        cmd_bank;
  logic              idle_req, wake_req, freq_chg_req, ref_done;
  logic              cke, dll_freeze, ready;
  logic [2:0]        pd_type;

  always #10 clk = ~clk;

  pdn_ctrl #(
    .NUM_BANKS (16),
    .TIME_W    (TIME_W),
    .REF_LIMIT (RLIM),
    .REF_GUARD (RGRD)
  ) dut (
    .clk (clk), .rst_n (rst_n), .cfg_x16 (cfg_x16), .cfg_slow_exit (cfg_slow_exit),
    .cfg_tcke (cfg_tcke), .cfg_txp (cfg_txp), .cfg_txpdll (cfg_txpdll),
    .cmd_valid (cmd_valid), .cmd_op (cmd_op), .cmd_bank (cmd_bank),
    .idle_req (idle_req), .wake_req (wake_req), .freq_chg_req (freq_chg_req),
    .ref_done (ref_done), .cke (cke), .dll_freeze (dll_freeze), .ready (ready),
    .pd_type (pd_type)
  );

  typedef struct {
    logic [2:0] ptype;
    logic       dll;
    int         exit_len;
    string      req;
  } exp_t;

  exp_t expq[$];
  int   checks = 0;
  int   fails  = 0;
  bit   mon_en = 1'b0;
  bit   done   = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic issue(input logic [2:0] op, input logic [3:0] bank);
    cmd_valid = 1'b1; cmd_op = op; cmd_bank = bank;
    step();
    cmd_valid = 1'b0; cmd_op = 3'd0; cmd_bank = 4'd0;
  endtask

  task automatic expect_pd(input logic [2:0] ptype, input string req);
    exp_t e;
    e.ptype    = ptype;
    e.dll      = (ptype == 3'b001);
    e.exit_len = (ptype == 3'b010) ? TXP : TXPDLL;
    e.req      = req;
    expq.push_back(e);
  endtask

  task automatic pulse_ref();
    ref_done = 1'b1; step(); ref_done = 1'b0;
  endtask

  task automatic pulse_idle();
    idle_req = 1'b1; step(); idle_req = 1'b0;
  endtask

  task automatic wait_ready();
    while (!ready) step();
  endtask

  task automatic pd_cycle(input logic [2:0] ptype, input int hold, input string req);
    expect_pd(ptype, req);
    pulse_ref();
    pulse_idle();
    step(hold);
    wake_req = 1'b1;
    wait_ready();
    wake_req = 1'b0;
    step(2);
  endtask

  // monitor: gathers one power-down episode and scores it
  int         low_n = 0;
  int         exit_n = 0;
  logic [2:0] seen_t = 3'b000;
  logic       seen_dll = 1'b0;
  logic       prev_ready = 1'b1;

  initial begin
    forever begin
      @(negedge clk);
      if (mon_en) begin
        if (cke && (dll_freeze || pd_type != 3'b000))
          chk(1'b0, "R5", "status while cke high", int'(pd_type), 0);
        if (!cke && ready)
          chk(1'b0, "R8", "ready while cke low", 1, 0);
        if (!ready) begin
          if (!cke) begin
            low_n++;
            if (pd_type != 3'b000) seen_t = pd_type;
            seen_dll = seen_dll | dll_freeze;
          end else begin
            exit_n++;
          end
        end else if (!prev_ready) begin
          if (expq.size() == 0) begin
            chk(1'b0, "R4", "unexpected power-down episode", 1, 0);
          end else begin
            exp_t e;
            e = expq.pop_front();
            chk(seen_t == e.ptype, e.req, "pd_type", int'(seen_t), int'(e.ptype));
            chk(seen_dll == e.dll, e.req, "dll_freeze", int'(seen_dll), int'(e.dll));
            chk(exit_n == e.exit_len, "R7", "exit wait cycles", exit_n, e.exit_len);
            chk(low_n >= TCKE, "R6", "cke low cycles", low_n, TCKE);
          end
          low_n = 0; exit_n = 0; seen_t = 3'b000; seen_dll = 1'b0;
        end
        prev_ready = ready;
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "WATCHDOG", "run did not finish", 0, 1);
    summary();
  end

  initial begin
    rst_n = 1'b0;
    cfg_x16 = 1'b0; cfg_slow_exit = 1'b0;
    cfg_tcke = TIME_W'(TCKE); cfg_txp = TIME_W'(TXP); cfg_txpdll = TIME_W'(TXPDLL);
    cmd_valid = 1'b0; cmd_op = 3'd0; cmd_bank = 4'd0;
    idle_req = 1'b0; wake_req = 1'b0; freq_chg_req = 1'b0; ref_done = 1'b0;
    step(3);
    // R1: reset values
    chk(cke == 1'b1, "R1", "cke in reset", int'(cke), 1);
    chk(ready == 1'b1, "R1", "ready in reset", int'(ready), 1);
    chk(dll_freeze == 1'b0, "R1", "dll_freeze in reset", int'(dll_freeze), 0);
    chk(pd_type == 3'b000, "R1", "pd_type in reset", int'(pd_type), 0);
    rst_n = 1'b1;
    step(3);
    chk(cke == 1'b1 && ready == 1'b1, "R1", "idle after reset", int'({cke, ready}), 3);
    mon_en = 1'b1;

    // R4: all banks closed -> precharge kind
    pd_cycle(3'b001, 4, "R4");
    // R4: idle request together with a command is not taken
    cmd_valid = 1'b1; cmd_op = 3'd0; idle_req = 1'b1;
    step();
    cmd_valid = 1'b0; idle_req = 1'b0;
    step(2);
    chk(cke == 1'b1, "R4", "entry with command in same cycle", int'(cke), 1);

    // R5: open row, fast then slow exit
    issue(3'd1, 4'd5);
    pd_cycle(3'b010, 3, "R5");
    cfg_slow_exit = 1'b1;
    pd_cycle(3'b100, 3, "R5");
    cfg_slow_exit = 1'b0;

    // R2: plain read keeps the row; wake at once also probes R6
    issue(3'd6, 4'd5);
    pd_cycle(3'b010, 0, "R2");
    // R2: read with auto-precharge closes it
    issue(3'd4, 4'd5);
    pd_cycle(3'b001, 2, "R2");
    // R2: partial close keeps one open, then close-all
    issue(3'd1, 4'd3);
    issue(3'd1, 4'd12);
    issue(3'd2, 4'd3);
    pd_cycle(3'b010, 2, "R2");
    issue(3'd3, 4'd0);
    pd_cycle(3'b001, 2, "R2");
    // R2: plain write keeps, write with auto-precharge closes
    issue(3'd1, 4'd7);
    issue(3'd7, 4'd7);
    pd_cycle(3'b010, 1, "R2");
    issue(3'd5, 4'd7);
    pd_cycle(3'b001, 1, "R2");

    // R3: 8-bank organisation folds bank 9 onto bank 1
    cfg_x16 = 1'b1;
    issue(3'd1, 4'd9);
    pd_cycle(3'b010, 2, "R3");
    issue(3'd2, 4'd1);
    pd_cycle(3'b001, 2, "R3");
    cfg_x16 = 1'b0;

    // R8: command during power-down is ignored
    expect_pd(3'b001, "R8");
    pulse_ref();
    pulse_idle();
    step(5);
    cmd_valid = 1'b1; cmd_op = 3'd1; cmd_bank = 4'd2;
    step();
    cmd_valid = 1'b0; cmd_op = 3'd0; cmd_bank = 4'd0;
    wake_req = 1'b1;
    wait_ready();
    wake_req = 1'b0;
    step(2);
    pd_cycle(3'b001, 2, "R8");

    // R9: active power-down held while frequency change pending
    issue(3'd1, 4'd0);
    expect_pd(3'b010, "R9");
    pulse_ref();
    freq_chg_req = 1'b1;
    pulse_idle();
    wake_req = 1'b1;
    step(12);
    chk(cke == 1'b0, "R9", "active exit with freq change pending", int'(cke), 0);
    freq_chg_req = 1'b0;
    wait_ready();
    wake_req = 1'b0;
    step(2);
    // R9: precharge power-down exits despite frequency change
    issue(3'd3, 4'd0);
    begin
      int n = 0;
      expect_pd(3'b001, "R9");
      pulse_ref();
      freq_chg_req = 1'b1;
      pulse_idle();
      wake_req = 1'b1;
      while (!ready && n < 40) begin step(); n++; end
      chk(ready == 1'b1 && n <= 20, "R9", "precharge exit cycles with freq change", n, 20);
      wake_req = 1'b0;
      freq_chg_req = 1'b0;
      wait_ready();
      step(2);
    end

    // R10: forced exit near the refresh deadline, no wake request
    begin
      int n = 0;
      expect_pd(3'b001, "R10");
      pulse_ref();
      pulse_idle();
      n = 1;
      while (!ready && n < 400) begin step(); n++; end
      chk(n >= RLIM - RGRD - 5 && n <= RLIM, "R10", "cycles from refresh to forced exit done",
          n, RLIM - RGRD + TXPDLL + 1);
      step(2);
      // R10: entry refused while urgent
      pulse_idle();
      step(3);
      chk(cke == 1'b1, "R10", "entry while refresh urgent", int'(cke), 1);
      chk(ready == 1'b1, "R10", "ready while refresh urgent", int'(ready), 1);
    end
    // R10: refresh clears urgency, entry works again
    pd_cycle(3'b001, 2, "R10");

    begin
      int n = 0;
      while (expq.size() != 0 && n < 50) begin step(); n++; end
      chk(expq.size() == 0, "R4", "episodes left unscored", expq.size(), 0);
    end
    summary();
  end

endmodule